// File: doc/BRIEF.md
# Per-256-Byte Hamming ECC Generator

This block watches a byte stream flowing to or from a NAND flash device and builds a single-error-correcting Hamming parity over each 256-byte chunk as the bytes go by. It works the same in either direction. Each byte is folded into a running accumulator. When the 256th byte of a chunk has been taken, the finished parity word is copied aside. The accumulator then restarts from zero, so the next chunk can follow with no gap and no help from software.

The finished 22-bit word is published one clock after the chunk's last byte. It stays on `par_word` until the next chunk completes. Bits 5:0 of the word hold column parity, which covers bit positions within a byte. Bits 21:6 hold line parity, which covers byte positions within the chunk. The block also gives the 3-byte form that is stored in the spare area, `spare_code`. The byte in bits 23:16 is stored first. Accumulation runs only while `ecc_en` is high, and a one-cycle pulse on `ecc_clr` wipes the partial chunk before a new transfer.

Inside, a small controller tracks the chunk with three states:
- `ST_IDLE`: no byte has been taken since reset, the last clear or the last publication.
- `ST_ACCUM`: part of a chunk has been taken.
- `ST_PUBLISH`: a one-cycle state entered after the 256th byte.

The transitions are:
- `IDLE->ACCUM` on an accepted byte.
- `ACCUM->PUBLISH` on the 256th accepted byte.
- `PUBLISH->ACCUM` if a byte is accepted in that cycle, otherwise `PUBLISH->IDLE`.
- Any state goes to `IDLE` on a clear. A clear in the `PUBLISH` cycle does not cancel the publication already under way.

Top module: `ecc256_gen`

## Requirements
- R1: After reset, `par_word` is 0, `res_done` is 0 and `spare_code` is 0xFFFFFF.
- R2: Column parity is the XOR over all chunk bytes of selected data bits. Bit 0 covers data bits with bit-number bit0 = 0, and bit 1 covers those with bit0 = 1. Bits 2 and 3 do the same on bit-number bit1, and bits 4 and 5 on bit-number bit2.
- R3: Line parity is the XOR of the byte parities of selected bytes. For byte-index bit k (k = 0..7), word bit 6+2k covers bytes whose index has bit k = 0, and word bit 7+2k covers bytes whose index has bit k = 1. The byte index is the position of the byte among accepted bytes since the chunk began, counting from 0.
- R4: Let the 256th accepted byte be taken at rising edge E. `res_done` is 0 after E, is 1 for exactly one cycle after edge E+1, and `par_word` takes the chunk's value at edge E+1.
- R5: After a chunk completes, the accumulator and byte index restart from zero. A chunk that follows with no idle cycle gets its own independent parity.
- R6: A byte presented with `byte_vld` = 1 while `ecc_en` = 0 is ignored: it neither advances the byte index nor alters parity.
- R7: An `ecc_clr` pulse zeroes the accumulator and the byte index. A byte presented in the same cycle as `ecc_clr` is discarded.
- R8: `spare_code` equals the bitwise inverse of `{par_word, 2'b00}` over 24 bits. Its bits 23:16 are the first stored byte, so `spare_code[1:0]` is always 2'b11.
- R9: A chunk of 256 bytes of 0xFF yields `par_word` = 0 and `spare_code` = 0xFFFFFF.
- R10: `par_word` changes only in a cycle where `res_done` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Parity accumulation enable |
| ecc_clr | input | 1 | One-cycle pulse that discards the partial chunk |
| byte_vld | input | 1 | A data byte is present on `byte_dat` |
| byte_dat | input | 8 | Data byte passing to or from the flash |
| par_word | output | 22 | Parity of the last completed chunk: line [21:6], column [5:0] |
| spare_code | output | 24 | Stored form of `par_word`, first stored byte in [23:16] |
| res_done | output | 1 | One-cycle pulse marking a new `par_word` |

## Verification
The functions that can fall in the same cycle are a clear pulse and an accepted byte. A clear can also land in the publication cycle of a finished chunk. The bench drives `ecc_clr` together with `byte_vld` and `ecc_en` high in one cycle, in the middle of a chunk of throwaway bytes. It then requires the following full chunk to publish exactly after its own 256th byte, with parity equal to a model of that chunk alone. That proves the coincident byte was neither counted nor folded in. A second chunk sent with no gap checks that the restart after the 256th byte and the first byte of the next chunk share a cycle cleanly.

// File: rtl/ecc256_pkg.sv
package ecc256_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCUM   = 2'd1,
        ST_PUBLISH = 2'd2
    } chunk_st_e;

endpackage

// File: rtl/ecc256_byte_term.sv
module ecc256_byte_term #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    localparam int COL_LEV = $clog2(DATA_W),
    localparam int COL_W   = 2 * COL_LEV,
    localparam int LINE_W  = 2 * IDX_W,
    localparam int PAR_W   = COL_W + LINE_W
) (
    input  logic [DATA_W-1:0] dat,
    input  logic [IDX_W-1:0]  idx,
    output logic [PAR_W-1:0]  term
);

    logic byte_par;
    assign byte_par = ^dat;

    for (genvar k = 0; k < COL_LEV; k++) begin : g_col
        logic [DATA_W-1:0] hi_mask;
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            localparam logic SEL = ((b >> k) & 1) != 0;
            assign hi_mask[b] = SEL;
        end
        assign term[2*k]   = ^(dat & ~hi_mask);
        assign term[2*k+1] = ^(dat & hi_mask);
    end

    for (genvar k = 0; k < IDX_W; k++) begin : g_line
        assign term[COL_W+2*k]   = byte_par & ~idx[k];
        assign term[COL_W+2*k+1] = byte_par & idx[k];
    end

endmodule

// File: rtl/ecc256_chunk_fsm.sv
module ecc256_chunk_fsm
    import ecc256_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             clr,
    output logic [IDX_W-1:0] idx,
    output logic             last,
    output logic             load_res,
    output logic             done_q
);

    chunk_st_e st, st_n;

    assign last     = take && (idx == {IDX_W{1'b1}});
    assign load_res = (st == ST_PUBLISH);

    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:    if (take) st_n = last ? ST_PUBLISH : ST_ACCUM;
            ST_ACCUM:   if (last) st_n = ST_PUBLISH;
            ST_PUBLISH: st_n = take ? (last ? ST_PUBLISH : ST_ACCUM) : ST_IDLE;
            default:    st_n = ST_IDLE;
        endcase
        if (clr) st_n = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            idx <= '0;
        end else begin
            st <= st_n;
            if (clr)       idx <= '0;
            else if (take) idx <= idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (st == ST_PUBLISH);
    end

endmodule

// File: rtl/ecc256_spare_pack.sv
module ecc256_spare_pack #(
    parameter int PAR_W   = 22,
    localparam int CODE_W = PAR_W + 2,
    localparam int NBYTES = (CODE_W + 7) / 8
) (
    input  logic [PAR_W-1:0]  par,
    output logic [CODE_W-1:0] code
);

    logic [CODE_W-1:0] shifted;
    assign shifted = {par, 2'b00};

    for (genvar n = 0; n < NBYTES; n++) begin : g_byte
        localparam int LO = n * 8;
        localparam int HI = (LO + 7 < CODE_W) ? LO + 7 : CODE_W - 1;
        assign code[HI:LO] = ~shifted[HI:LO];
    end

endmodule

// File: rtl/ecc256_gen.sv
module ecc256_gen #(
    parameter int DATA_W      = 8,
    parameter int CHUNK_BYTES = 256,
    localparam int IDX_W   = $clog2(CHUNK_BYTES),
    localparam int COL_W   = 2 * $clog2(DATA_W),
    localparam int PAR_W   = COL_W + 2 * IDX_W,
    localparam int CODE_W  = PAR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en,
    input  logic              ecc_clr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_dat,
    output logic [PAR_W-1:0]  par_word,
    output logic [CODE_W-1:0] spare_code,
    output logic              res_done
);

    logic             take;
    logic             last;
    logic             load_res;
    logic [IDX_W-1:0] byte_idx;
    logic [PAR_W-1:0] term;
    logic [PAR_W-1:0] acc;
    logic [PAR_W-1:0] hold;

    assign take = ecc_en && byte_vld && !ecc_clr;

    ecc256_byte_term #(.DATA_W(DATA_W), .IDX_W(IDX_W)) term_i (
        .dat  (byte_dat),
        .idx  (byte_idx),
        .term (term)
    );

    ecc256_chunk_fsm #(.IDX_W(IDX_W)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .clr      (ecc_clr),
        .idx      (byte_idx),
        .last     (last),
        .load_res (load_res),
        .done_q   (res_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc      <= '0;
            hold     <= '0;
            par_word <= '0;
        end else begin
            if (ecc_clr)   acc <= '0;
            else if (take) acc <= last ? '0 : (acc ^ term);
            if (last)      hold <= acc ^ term;
            if (load_res)  par_word <= hold;
        end
    end

    ecc256_spare_pack #(.PAR_W(PAR_W)) pack_i (
        .par  (par_word),
        .code (spare_code)
    );

endmodule

module ecc256_gen_chk #(
    parameter int IDX_W  = 8,
    parameter int PAR_W  = 22,
    parameter int CODE_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ecc_en,
    input logic              ecc_clr,
    input logic [IDX_W-1:0]  byte_idx,
    input logic [PAR_W-1:0]  par_word,
    input logic [CODE_W-1:0] spare_code,
    input logic              res_done
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |=> !res_done); // R4

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_done |-> $stable(par_word)); // R10

    AST_SPARE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        spare_code[1:0] == 2'b11); // R8

    AST_ERASED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (par_word == '0) |-> (spare_code == {CODE_W{1'b1}})); // R9

    AST_GATED_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_en && !ecc_clr) |=> $stable(byte_idx)); // R6

    AST_CLR_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_clr |=> (byte_idx == '0)); // R7

endmodule

bind ecc256_gen ecc256_gen_chk #(.IDX_W(IDX_W), .PAR_W(PAR_W), .CODE_W(CODE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ecc_en     (ecc_en),
    .ecc_clr    (ecc_clr),
    .byte_idx   (byte_idx),
    .par_word   (par_word),
    .spare_code (spare_code),
    .res_done   (res_done)
);

// File: tb/ecc256_gen_tb.sv
`timescale 1ns/1ps
module ecc256_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_en = 1'b0;
    logic        ecc_clr = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_dat = 8'h00;
    logic [21:0] par_word;
    logic [23:0] spare_code;
    logic        res_done;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] mem [2][256];

    always #2.5 clk = ~clk;

    ecc256_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ecc_en     (ecc_en),
        .ecc_clr    (ecc_clr),
        .byte_vld   (byte_vld),
        .byte_dat   (byte_dat),
        .par_word   (par_word),
        .spare_code (spare_code),
        .res_done   (res_done)
    );

    function automatic logic [21:0] model(input int sel);
        logic [21:0] w = '0;
        for (int i = 0; i < 256; i++)
            for (int b = 0; b < 8; b++)
                if (mem[sel][i][b]) begin
                    for (int k = 0; k < 3; k++) w[2*k + ((b >> k) & 1)] ^= 1'b1;
                    for (int k = 0; k < 8; k++) w[6 + 2*k + ((i >> k) & 1)] ^= 1'b1;
                end
        return w;
    endfunction

    function automatic logic [23:0] spare_of(input logic [21:0] w);
        logic [23:0] s = 24'hFFFFFF;
        for (int b = 0; b < 22; b++) s[b+2] = ~w[b];
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input bit en, input bit vld, input bit clr, input logic [7:0] d);
        @(negedge clk);
        ecc_en = en; byte_vld = vld; ecc_clr = clr; byte_dat = d;
        @(posedge clk);
    endtask

    task automatic tail(input logic [21:0] w, input string req);
        @(negedge clk);
        chk(res_done == 1'b0, "R4 no done right after last byte", {31'd0, res_done}, 32'd0);
        byte_vld = 1'b0; ecc_clr = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(res_done == 1'b1, "R4 done one cycle later", {31'd0, res_done}, 32'd1);
        chk(par_word == w, req, {10'd0, par_word}, {10'd0, w});
        chk(spare_code == spare_of(w), "R8 stored form", {8'd0, spare_code}, {8'd0, spare_of(w)});
        @(posedge clk);
        @(negedge clk);
        chk(res_done == 1'b0, "R4 done lasts one cycle", {31'd0, res_done}, 32'd0);
    endtask

    task automatic feed(input bit gated, input string req);
        logic [21:0] w;
        w = model(0);
        for (int j = 0; j < 256; j++) begin
            if (gated) put(1'b0, 1'b1, 1'b0, 8'(j * 37 + 5));
            put(1'b1, 1'b1, 1'b0, mem[0][j]);
        end
        tail(w, req);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(par_word == '0, "R1 word reset", {10'd0, par_word}, 32'd0);
        chk(res_done == 1'b0, "R1 done reset", {31'd0, res_done}, 32'd0);
        chk(spare_code == 24'hFFFFFF, "R1 spare reset", {8'd0, spare_code}, 32'hFFFFFF);
    endtask

    task automatic t_col_single;
        for (int j = 0; j < 256; j++) mem[0][j] = 8'h00;
        mem[0][5] = 8'h01;
        feed(1'b0, "R2 single bit 0 at byte 5");
        chk(par_word[5:0] == 6'b010101, "R2 column bits", {26'd0, par_word[5:0]}, 32'h15);
    endtask

    task automatic t_line_single;
        for (int j = 0; j < 256; j++) mem[0][j] = 8'h00;
        mem[0][8'hA3] = 8'h40;
        feed(1'b0, "R3 single bit 6 at byte A3");
        chk(par_word[21:6] == 16'b1001100101011010, "R3 line bits", {16'd0, par_word[21:6]}, 32'h995A);
    endtask

    task automatic t_ramp;
        for (int j = 0; j < 256; j++) mem[0][j] = 8'(j);
        feed(1'b0, "R2 R3 ramp chunk");
    endtask

    task automatic t_lfsr;
        logic [7:0] s = 8'hA5;
        for (int j = 0; j < 256; j++) begin
            mem[0][j] = s;
            s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
        end
        feed(1'b0, "R2 R3 pseudo-random chunk");
    endtask

    task automatic t_erased;
        for (int j = 0; j < 256; j++) mem[0][j] = 8'hFF;
        feed(1'b0, "R9 erased chunk word");
        chk(spare_code == 24'hFFFFFF, "R9 erased stored form", {8'd0, spare_code}, 32'hFFFFFF);
    endtask

    task automatic t_gated;
        for (int j = 0; j < 256; j++) mem[0][j] = 8'(j * 11 + 3);
        feed(1'b1, "R6 disabled bytes ignored");
    endtask

    task automatic t_clear;
        for (int j = 0; j < 77; j++) put(1'b1, 1'b1, 1'b0, 8'(j * 29 + 1));
        put(1'b1, 1'b1, 1'b1, 8'h5A);
        for (int j = 0; j < 256; j++) mem[0][j] = 8'(j ^ 8'h3C);
        feed(1'b0, "R7 clear with coincident byte");
    endtask

    task automatic t_b2b;
        logic [21:0] wa, wb;
        for (int j = 0; j < 256; j++) begin
            mem[0][j] = 8'(j * 7);
            mem[1][j] = 8'(255 - j * 3);
        end
        wa = model(0);
        wb = model(1);
        for (int j = 0; j < 512; j++) begin
            @(negedge clk);
            if (j == 256) chk(res_done == 1'b0, "R5 first chunk done timing", {31'd0, res_done}, 32'd0);
            if (j == 257) begin
                chk(res_done == 1'b1, "R5 first chunk done", {31'd0, res_done}, 32'd1);
                chk(par_word == wa, "R5 first chunk word", {10'd0, par_word}, {10'd0, wa});
            end
            ecc_en = 1'b1; byte_vld = 1'b1; ecc_clr = 1'b0;
            byte_dat = mem[j / 256][j % 256];
            @(posedge clk);
        end
        tail(wb, "R5 second chunk independent");
    endtask

    task automatic t_hold;
        logic [21:0] w;
        @(negedge clk);
        w = par_word;
        for (int j = 0; j < 40; j++) put(1'b1, 1'b1, 1'b0, 8'(j));
        @(negedge clk);
        chk(par_word == w, "R10 word held mid-chunk", {10'd0, par_word}, {10'd0, w});
        put(1'b0, 1'b0, 1'b1, 8'h00);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_col_single();
        t_line_single();
        t_ramp();
        t_lfsr();
        t_erased();
        t_gated();
        t_clear();
        t_b2b();
        t_hold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule